// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the 64-bit control registers of a processor core. A single read port and a single write port reach them by a 6-bit index. Each register keeps only the bits its write mask allows. Some registers clear on any write. Some can only be read, and some only take commands. Any access the index does not allow raises a fault flag and leaves all state alone. The flag does not rely on a stored value.

One register merges two sources. Its upper half is stored state. Its lower half is a free-running cycle counter. Writes to the invalidate-command indices raise one-cycle strobes toward the instruction-side and data-side translation buffers. Single-entry invalidates also carry the written address and the current address-space number of the matching side. Reads are combinational. Writes land on the rising clock edge.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every readable index reads zero, except the handler base at index 0x10, which reads the parameter HANDLER_RESET, and the machine control register at 0x1F, which reads 0x6. Scratch indices 0x00 to NUM_SCRATCH-1, 0x10 and 0x1F keep all 64 written bits.
- R2: A write to the restart address register at 0x11 stores the data with bit 1 forced to zero.
- R3: Narrow masks: 0x12 and 0x13 keep mask 0xF. 0x14 keeps 0x1F. 0x15 and 0x16 keep 0x18. 0x17 keeps 0x7FFF0.
- R4: Wide masks: 0x18 keeps 0xFFFFFF0300. 0x19 and 0x1A keep 0xFFFFFFFFC0000000. 0x1B keeps 0x1FFB. 0x1C keeps 0x3F. 0x1D keeps 0x7F0. 0x1E keeps 0xFE00000000000000.
- R5: Any write to 0x20 or 0x21 leaves that register zero, whatever the data, and does not fault.
- R6: Index 0x22 reads as {stored bits 63:32, counter bits 31:0}. The counter is zero in the first cycle after reset and advances by one every clock. A write stores the data but leaves the counter alone.
- R7: Indices 0x23 to 0x27 read zero without a fault. Writes to them raise wrFault and change nothing.
- R8: Indices 0x28 to 0x31 accept writes without a fault. Reads of them raise rdFault and return zero.
- R9: In the cycle a write is presented to 0x2C, 0x2D, 0x2E, 0x2F, 0x30 or 0x31, exactly one strobe is high: invDataAll, invDataProc, invDataOne, invInstAll, invInstProc or invInstOne, respectively. invDataOne and invInstOne drive invAddr with wrData. They drive invAsn with bits 63:57 of 0x1E or bits 10:4 of 0x1D, respectively. Otherwise invAddr and invAsn are zero.
- R10: Indices NUM_SCRATCH to 0x0F and 0x32 to 0x3F fault on both read and write, read zero, and change nothing.
- R11: rdData follows rdIdx in the same cycle. A read of the index being written returns the old value, and the new value appears from the next cycle. With rdEn or wrEn low, the matching fault is low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read request |
| rdIdx | input | 6 | Read index |
| rdData | output | 64 | Read data, zero when not legal |
| rdFault | output | 1 | Illegal read |
| wrEn | input | 1 | Write request |
| wrIdx | input | 6 | Write index |
| wrData | input | 64 | Write data |
| wrFault | output | 1 | Illegal write |
| invDataAll | output | 1 | Data-side invalidate all |
| invDataProc | output | 1 | Data-side invalidate per-process entries |
| invDataOne | output | 1 | Data-side single-entry invalidate |
| invInstAll | output | 1 | Instruction-side invalidate all |
| invInstProc | output | 1 | Instruction-side invalidate per-process entries |
| invInstOne | output | 1 | Instruction-side single-entry invalidate |
| invAddr | output | 64 | Address for a single-entry invalidate |
| invAsn | output | 7 | Address-space number for a single-entry invalidate |

## Verification
The bench builds the bank with NUM_SCRATCH set to 4. This leaves indices 4 to 15 undefined, so the fault path is probed in the gap between the scratch block and the named registers. It also probes above the command range. HANDLER_RESET is set to an asymmetric value with bits in both halves, so a reset value taken from the wrong place or a truncated parameter shows at the first read. CNT_W stays at 32, so the merged cycle register is checked at its natural split.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int IDX_W    = 6;
  localparam int REG_W    = 64;
  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int ASN_W    = 7;
  localparam int DASN_LSB = 57;
  localparam int IASN_LSB = 4;

  localparam logic [IDX_W-1:0] IX_HBASE   = 6'h10;
  localparam logic [IDX_W-1:0] IX_RESTART = 6'h11;
  localparam logic [IDX_W-1:0] IX_TRAPREQ = 6'h12;
  localparam logic [IDX_W-1:0] IX_TRAPEN  = 6'h13;
  localparam logic [IDX_W-1:0] IX_IPL     = 6'h14;
  localparam logic [IDX_W-1:0] IX_IMODE   = 6'h15;
  localparam logic [IDX_W-1:0] IX_DMODE   = 6'h16;
  localparam logic [IDX_W-1:0] IX_SWINT   = 6'h17;
  localparam logic [IDX_W-1:0] IX_CTLSTAT = 6'h18;
  localparam logic [IDX_W-1:0] IX_IPTB    = 6'h19;
  localparam logic [IDX_W-1:0] IX_DPTB    = 6'h1A;
  localparam logic [IDX_W-1:0] IX_CTEST   = 6'h1B;
  localparam logic [IDX_W-1:0] IX_CMODE   = 6'h1C;
  localparam logic [IDX_W-1:0] IX_IASN    = 6'h1D;
  localparam logic [IDX_W-1:0] IX_DASN    = 6'h1E;
  localparam logic [IDX_W-1:0] IX_MCTL    = 6'h1F;
  localparam logic [IDX_W-1:0] IX_EXCSUM  = 6'h20;
  localparam logic [IDX_W-1:0] IX_EXCMSK  = 6'h21;
  localparam logic [IDX_W-1:0] IX_CYCLE   = 6'h22;
  localparam logic [IDX_W-1:0] IX_RO_LO   = 6'h23;
  localparam logic [IDX_W-1:0] IX_RO_HI   = 6'h27;
  localparam logic [IDX_W-1:0] IX_CMD_LO  = 6'h28;
  localparam logic [IDX_W-1:0] IX_DINV_ALL  = 6'h2C;
  localparam logic [IDX_W-1:0] IX_DINV_PROC = 6'h2D;
  localparam logic [IDX_W-1:0] IX_DINV_ONE  = 6'h2E;
  localparam logic [IDX_W-1:0] IX_IINV_ALL  = 6'h2F;
  localparam logic [IDX_W-1:0] IX_IINV_PROC = 6'h30;
  localparam logic [IDX_W-1:0] IX_IINV_ONE  = 6'h31;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] wrIdx;
    logic             rdOk;
    logic             rdCycle;
    logic             invDataAll;
    logic             invDataProc;
    logic             invDataOne;
    logic             invInstAll;
    logic             invInstProc;
    logic             invInstOne;
  } crfCmd_t;

  // Index holds a register with storage behind it.
  function automatic logic isStored(input logic [IDX_W-1:0] idx, input int nScr);
    return (int'(idx) < nScr) || (idx >= IX_HBASE && idx <= IX_CYCLE);
  endfunction

  function automatic logic isReadOnly(input logic [IDX_W-1:0] idx);
    return idx >= IX_RO_LO && idx <= IX_RO_HI;
  endfunction

  function automatic logic isCommand(input logic [IDX_W-1:0] idx);
    return idx >= IX_CMD_LO && idx <= IX_IINV_ONE;
  endfunction

  function automatic logic [REG_W-1:0] writeMask(input logic [IDX_W-1:0] idx);
    logic [REG_W-1:0] m;
    case (idx)
      IX_RESTART:            m = ~REG_W'(64'h2);
      IX_TRAPREQ, IX_TRAPEN: m = REG_W'(64'hF);
      IX_IPL:                m = REG_W'(64'h1F);
      IX_IMODE, IX_DMODE:    m = REG_W'(64'h18);
      IX_SWINT:              m = REG_W'(64'h7_FFF0);
      IX_CTLSTAT:            m = REG_W'(64'hFF_FFFF_0300);
      IX_IPTB, IX_DPTB:      m = REG_W'(64'hFFFF_FFFF_C000_0000);
      IX_CTEST:              m = REG_W'(64'h1FFB);
      IX_CMODE:              m = REG_W'(64'h3F);
      IX_IASN:               m = REG_W'(64'h7F0);
      IX_DASN:               m = REG_W'(64'hFE00_0000_0000_0000);
      IX_EXCSUM, IX_EXCMSK:  m = '0;
      default:               m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [REG_W-1:0] resetVal(input logic [IDX_W-1:0] idx,
                                                input logic [REG_W-1:0] hbase);
    if (idx == IX_HBASE) return hbase;
    if (idx == IX_MCTL)  return REG_W'(64'h6);
    return '0;
  endfunction
endpackage

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
#(
  parameter int NUM_SCRATCH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output crfCmd_t          cmd,
  output logic             rdFault,
  output logic             wrFault
);
  logic rdLegal, wrStore, wrLegal;

  always_comb begin
    rdLegal = isStored(rdIdx, NUM_SCRATCH) || isReadOnly(rdIdx);
    wrStore = isStored(wrIdx, NUM_SCRATCH);
    wrLegal = wrStore || isCommand(wrIdx);
  end

  always_comb begin
    cmd         = '0;
    cmd.rdOk    = rdEn && rdLegal;
    cmd.rdCycle = (rdIdx == IX_CYCLE);
    cmd.load    = wrEn && wrStore;
    cmd.wrIdx   = wrIdx;
    if (wrEn) begin
      case (wrIdx)
        IX_DINV_ALL:  cmd.invDataAll  = 1'b1;
        IX_DINV_PROC: cmd.invDataProc = 1'b1;
        IX_DINV_ONE:  cmd.invDataOne  = 1'b1;
        IX_IINV_ALL:  cmd.invInstAll  = 1'b1;
        IX_IINV_PROC: cmd.invInstProc = 1'b1;
        IX_IINV_ONE:  cmd.invInstOne  = 1'b1;
        default: ;
      endcase
    end
  end

  assign rdFault = rdEn && !rdLegal;
  assign wrFault = wrEn && !wrLegal;

  // A faulting write must neither load storage nor raise any strobe.
  assert_fault_inert_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> !cmd.load && !(cmd.invDataAll || cmd.invDataProc || cmd.invDataOne ||
                               cmd.invInstAll || cmd.invInstProc || cmd.invInstOne));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.invDataAll, cmd.invDataProc, cmd.invDataOne,
              cmd.invInstAll, cmd.invInstProc, cmd.invInstOne}));

  // Strobes only follow a legal command write.
  assert_strobe_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.invDataOne || cmd.invInstOne) |-> wrEn && !wrFault);
endmodule

// File: rtl/crf_datapath.sv
module crf_datapath
  import crf_pkg::*;
#(
  parameter int               NUM_SCRATCH   = 8,
  parameter logic [REG_W-1:0] HANDLER_RESET = '0,
  parameter int               CNT_W         = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  crfCmd_t          cmd,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             invDataAll,
  output logic             invDataProc,
  output logic             invDataOne,
  output logic             invInstAll,
  output logic             invInstProc,
  output logic             invInstOne,
  output logic [REG_W-1:0] invAddr,
  output logic [ASN_W-1:0] invAsn
);
  localparam int HI_W = REG_W - CNT_W;

  logic [REG_W-1:0] regQ [NUM_IDX];
  logic [CNT_W-1:0] cycCnt;

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    if (isStored(SLOT, NUM_SCRATCH)) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          q <= resetVal(SLOT, HANDLER_RESET);
        else if (cmd.load && cmd.wrIdx == SLOT)
          q <= wrData & writeMask(SLOT);
      end
      assign regQ[i] = q;
    end else begin : g_none
      assign regQ[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycCnt <= '0;
    else       cycCnt <= cycCnt + CNT_W'(1);
  end

  always_comb begin
    if (!cmd.rdOk)
      rdData = '0;
    else if (cmd.rdCycle)
      rdData = {regQ[IX_CYCLE][REG_W-1 -: HI_W], cycCnt};
    else
      rdData = regQ[rdIdx];
  end

  assign invDataAll  = cmd.invDataAll;
  assign invDataProc = cmd.invDataProc;
  assign invDataOne  = cmd.invDataOne;
  assign invInstAll  = cmd.invInstAll;
  assign invInstProc = cmd.invInstProc;
  assign invInstOne  = cmd.invInstOne;

  always_comb begin
    invAddr = '0;
    invAsn  = '0;
    if (cmd.invDataOne) begin
      invAddr = wrData;
      invAsn  = regQ[IX_DASN][DASN_LSB +: ASN_W];
    end else if (cmd.invInstOne) begin
      invAddr = wrData;
      invAsn  = regQ[IX_IASN][IASN_LSB +: ASN_W];
    end
  end

  assert_restart_bit1_R2: assert property (@(posedge clk) disable iff (!rstN)
    regQ[IX_RESTART][1] == 1'b0);

  assert_ipl_narrow_R3: assert property (@(posedge clk) disable iff (!rstN)
    regQ[IX_IPL][REG_W-1:5] == '0);

  assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cycCnt == $past(cycCnt) + CNT_W'(1));

  assert_sum_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load && cmd.wrIdx == IX_EXCSUM |=> regQ[IX_EXCSUM] == '0);
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crf_pkg::*;
#(
  parameter int               NUM_SCRATCH   = 8,
  parameter logic [REG_W-1:0] HANDLER_RESET = 64'h0000_0000_0000_4000,
  parameter int               CNT_W         = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic [5:0]  rdIdx,
  output logic [63:0] rdData,
  output logic        rdFault,
  input  logic        wrEn,
  input  logic [5:0]  wrIdx,
  input  logic [63:0] wrData,
  output logic        wrFault,
  output logic        invDataAll,
  output logic        invDataProc,
  output logic        invDataOne,
  output logic        invInstAll,
  output logic        invInstProc,
  output logic        invInstOne,
  output logic [63:0] invAddr,
  output logic [6:0]  invAsn
);
  crfCmd_t cmd;

  crf_ctrl #(.NUM_SCRATCH(NUM_SCRATCH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx),
    .cmd(cmd), .rdFault(rdFault), .wrFault(wrFault)
  );

  crf_datapath #(
    .NUM_SCRATCH(NUM_SCRATCH), .HANDLER_RESET(HANDLER_RESET), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdIdx(rdIdx), .wrData(wrData),
    .rdData(rdData),
    .invDataAll(invDataAll), .invDataProc(invDataProc), .invDataOne(invDataOne),
    .invInstAll(invInstAll), .invInstProc(invInstProc), .invInstOne(invInstOne),
    .invAddr(invAddr), .invAsn(invAsn)
  );
endmodule

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/1ps
module ctrl_reg_bank_test;
  localparam int          NSCR = 4;
  localparam logic [63:0] HRST = 64'hC001_0000_0000_A000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [5:0] rdIdx = '0, wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData, invAddr;
  logic rdFault, wrFault;
  logic invDataAll, invDataProc, invDataOne, invInstAll, invInstProc, invInstOne;
  logic [6:0] invAsn;

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0] mdl [64];
  logic [31:0] mdlCyc;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  ctrl_reg_bank #(.NUM_SCRATCH(NSCR), .HANDLER_RESET(HRST)) uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData), .rdFault(rdFault),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .wrFault(wrFault),
    .invDataAll(invDataAll), .invDataProc(invDataProc), .invDataOne(invDataOne),
    .invInstAll(invInstAll), .invInstProc(invInstProc), .invInstOne(invInstOne),
    .invAddr(invAddr), .invAsn(invAsn)
  );

  // Reference tables, written from the requirement text.
  function automatic logic [63:0] specMask(input int i);
    if (i == 'h20 || i == 'h21) return 64'h0;
    if (i == 'h1E) return 64'hFE00_0000_0000_0000;
    if (i == 'h1D) return 64'h7F0;
    if (i == 'h1C) return 64'h3F;
    if (i == 'h1B) return 64'h1FFB;
    if (i == 'h19 || i == 'h1A) return 64'hFFFF_FFFF_C000_0000;
    if (i == 'h18) return 64'hFF_FFFF_0300;
    if (i == 'h17) return 64'h7_FFF0;
    if (i == 'h15 || i == 'h16) return 64'h18;
    if (i == 'h14) return 64'h1F;
    if (i == 'h12 || i == 'h13) return 64'hF;
    if (i == 'h11) return 64'hFFFF_FFFF_FFFF_FFFD;
    return '1;
  endfunction

  function automatic bit specStores(input int i);
    return (i < NSCR) || (i >= 'h10 && i <= 'h22);
  endfunction

  function automatic bit specReadable(input int i);
    return specStores(i) || (i >= 'h23 && i <= 'h27);
  endfunction

  function automatic bit specWritable(input int i);
    return specStores(i) || (i >= 'h28 && i <= 'h31);
  endfunction

  task automatic resetModel();
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mdl['h10] = HRST;
    mdl['h1F] = 64'h6;
    mdlCyc = '0;
  endtask

  task automatic step(input logic re, input logic [5:0] ri, input logic we,
                      input logic [5:0] wi, input logic [63:0] wd, input string tag);
    logic [63:0] eRd, eAddr;
    logic eRf, eWf;
    logic [5:0] eStb, aStb;
    logic [6:0] eAsn;
    rdEn = re; rdIdx = ri; wrEn = we; wrIdx = wi; wrData = wd;
    #1;
    eRf = re && !specReadable(int'(ri));
    eWf = we && !specWritable(int'(wi));
    eRd = '0;
    if (re && specReadable(int'(ri)))
      eRd = (ri == 6'h22) ? {mdl['h22][63:32], mdlCyc} : mdl[ri];
    eStb = '0; eAddr = '0; eAsn = '0;
    if (we) begin
      case (wi)
        6'h2C: eStb = 6'b100000;
        6'h2D: eStb = 6'b010000;
        6'h2E: begin eStb = 6'b001000; eAddr = wd; eAsn = mdl['h1E][63:57]; end
        6'h2F: eStb = 6'b000100;
        6'h30: eStb = 6'b000010;
        6'h31: begin eStb = 6'b000001; eAddr = wd; eAsn = mdl['h1D][10:4]; end
        default: ;
      endcase
    end
    aStb = {invDataAll, invDataProc, invDataOne, invInstAll, invInstProc, invInstOne};
    nChecks++;
    if (rdData !== eRd || rdFault !== eRf || wrFault !== eWf || aStb !== eStb ||
        invAddr !== eAddr || invAsn !== eAsn) begin
      nFails++;
      $display("FAIL %s rd[%h] wr[%h]: actual rd=%h rf=%b wf=%b stb=%b addr=%h asn=%h expected rd=%h rf=%b wf=%b stb=%b addr=%h asn=%h",
               tag, ri, wi, rdData, rdFault, wrFault, aStb, invAddr, invAsn,
               eRd, eRf, eWf, eStb, eAddr, eAsn);
    end
    @(posedge clk);
    if (we && specStores(int'(wi))) mdl[wi] = wd & specMask(int'(wi));
    mdlCyc = mdlCyc + 32'd1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] i, input logic [63:0] d, input string tag);
    step(1'b1, i, 1'b1, i, d, tag);
  endtask

  task automatic rd(input logic [5:0] i, input string tag);
    step(1'b1, i, 1'b0, 6'h0, 64'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [5:0] maskList [15];
    maskList = '{6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h19,
                 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h11, 6'h1F};
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents across the whole index space
    for (int i = 0; i < 64; i++) rd(6'(i), "R1");
    // R1: full-width registers
    for (int i = 0; i < NSCR; i++) begin
      wr(6'(i), 64'hDEAD_BEEF_0123_4567 ^ 64'(i), "R1");
      rd(6'(i), "R1");
    end
    wr(6'h10, 64'hFFFF_FFFF_FFFF_FFFF, "R1"); rd(6'h10, "R1");
    wr(6'h1F, 64'h8000_0000_0000_0001, "R1"); rd(6'h1F, "R1");
    // R2: restart bit 1 forced low
    wr(6'h11, '1, "R2"); rd(6'h11, "R2");
    wr(6'h11, 64'h2, "R2"); rd(6'h11, "R2");
    // R3 and R4: masks
    foreach (maskList[k]) begin
      wr(maskList[k], '1, (maskList[k] <= 6'h17) ? "R3" : "R4");
      rd(maskList[k], (maskList[k] <= 6'h17) ? "R3" : "R4");
      wr(maskList[k], 64'h5A5A_C3C3_0F0F_9669, (maskList[k] <= 6'h17) ? "R3" : "R4");
      rd(maskList[k], (maskList[k] <= 6'h17) ? "R3" : "R4");
    end
    // R5: write clears
    wr(6'h20, '1, "R5"); rd(6'h20, "R5");
    wr(6'h21, 64'h1234, "R5"); rd(6'h21, "R5");
    // R6: merged cycle register
    rd(6'h22, "R6"); rd(6'h22, "R6"); rd(6'h22, "R6");
    wr(6'h22, 64'h1234_5678_9ABC_DEF0, "R6");
    rd(6'h22, "R6"); rd(6'h22, "R6");
    // R7: read-only indices
    for (int i = 'h23; i <= 'h27; i++) begin
      wr(6'(i), '1, "R7"); rd(6'(i), "R7");
    end
    // R8: write-only indices
    for (int i = 'h28; i <= 'h31; i++) rd(6'(i), "R8");
    for (int i = 'h28; i <= 'h2B; i++) wr(6'(i), 64'hA5A5_0000_FFFF_1111, "R8");
    // R9: invalidate strobes with ASN sources loaded
    wr(6'h1E, 64'hAB00_0000_0000_0000, "R9");
    wr(6'h1D, 64'h3A0, "R9");
    for (int i = 'h2C; i <= 'h31; i++) wr(6'(i), 64'h0000_7FFF_1234_5000 + 64'(i), "R9");
    step(1'b0, 6'h0, 1'b1, 6'h2E, 64'h0000_0000_0000_0000, "R9");
    // R10: undefined indices
    for (int i = NSCR; i < 'h10; i++) begin wr(6'(i), '1, "R10"); rd(6'(i), "R10"); end
    for (int i = 'h32; i < 64; i++) begin wr(6'(i), '1, "R10"); rd(6'(i), "R10"); end
    for (int i = 0; i < NSCR; i++) rd(6'(i), "R10");
    // R11: timing and enables
    step(1'b0, 6'h3F, 1'b0, 6'h3F, '1, "R11");
    step(1'b0, 6'h00, 1'b0, 6'h00, 64'h77, "R11");
    rd(6'h00, "R11");
    wr(6'h01, 64'h0F0F_0F0F_0F0F_0F0F, "R11");
    wr(6'h01, 64'hF0F0_F0F0_F0F0_F0F0, "R11");
    rd(6'h01, "R11");
    // R11: mixed traffic across the full index space
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      step(lfsr[0], lfsr[12:7], lfsr[1], lfsr[20:15], {lfsr[31:0], lfsr[63:32]}, "R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule